// File: doc/BRIEF.md
# External Interrupt Trigger-Sense Controller

This block turns up to six asynchronous external interrupt pins into per-line interrupt requests. Every pin passes through a two-flop synchronizer. A per-line trigger type then decides whether the line reports a level or an edge. The type can be high level, low level, rising edge, falling edge or either edge. Level events follow the synchronized pin with no memory. Edge events are held in a per-line latch until software acknowledges them by writing a clear bit.

Software reaches the configuration through 32-bit words, each covering four lines, so six lines need two words. Each line has an enable bit, a write-one clear pulse, three type bits and a read-only status bit. A request is the line's status gated by its enable. A mode input sends the requests either straight to processor interrupt inputs or to an internal aggregator. In aggregator mode the line enables are also exported, so the aggregator's matching sources are enabled or disabled along with the external lines.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0 and every line is level-low (level bit 1, polarity 0, both-edge 0). All request outputs are 0 and no edge is latched. With all pins low, word 0 reads 0x00F0000F and word 1 reads 0x00300003.
- R2: Level-high (level 1, polarity 1, both-edge 0): status equals the synchronized pin. It is not latched. A pin change reaches the request output after the second rising clock edge.
- R3: Level-low (level 1, polarity 0, both-edge 0): status is the inverse of the synchronized pin. It is not latched.
- R4: Rising edge (level 0, polarity 1, both-edge 0): a 0-to-1 transition sets the line's latch on the third clock edge after the pin changes. The latch stays set after the pin falls again.
- R5: Falling edge (all three type bits 0): a 1-to-0 transition sets the latch, and a rising transition has no effect.
- R6: Both edges (both-edge 1, level 0, polarity 0): either transition sets the latch.
- R7: Writing 1 to a line's clear bit (bit 4+k of the word) empties its latch on that write's clock edge. The clear bit always reads 0. If a new edge is detected on the same clock edge as the clear, the latch stays set.
- R8: A request is status AND enable (enable bit 8+k). The status bit (bit k) reads back whether or not the line is enabled.
- R9: A write whose type bits for a line have both-edge set together with level or polarity is refused for that line, which keeps its previous type. The enable bit in the same write is still applied.
- R10: Line i sits in word i/4 at position k = i mod 4. The fields are status [k], clear [4+k], enable [8+k], polarity [12+k], both-edge [16+k] and level [20+k]. Positions in word 1 with no line read 0 and ignore writes.
- R11: With `cascade_i` low, requests appear on `cpu_irq_o` and both aggregator outputs are 0. With it high, requests appear on `agg_req_o`, the enable bits appear on `agg_en_o`, and `cpu_irq_o` is 0.
- R12: While a line is level-typed, its edge latch is emptied. A stale edge therefore does not reappear when the line returns to an edge type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 6 | Asynchronous external interrupt pins |
| cascade_i | input | 1 | 1 routes requests to the aggregator, 0 to the processor inputs |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wr_idx_i | input | 1 | Word index for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rd_idx_i | input | 1 | Word index for the read |
| cfg_rdata_o | output | 32 | Read data for the selected word (combinational) |
| cpu_irq_o | output | 6 | Per-line requests in direct mode |
| agg_req_o | output | 6 | Per-line requests in aggregator mode |
| agg_en_o | output | 6 | Per-line enables exported in aggregator mode |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock edge on which a new edge is detected. The latch must survive that clear, and the timing window is a single cycle about three edges after the pin moves. The stimulus places the clear write exactly two clock steps after raising the pin, so that the write's active edge coincides with the detection edge. A behavioural model compared on every clock confirms that all other lines stay undisturbed. Refused type combinations and the flushing of a stale latch through level mode are reached by rewriting the same word several times between pin transitions.

// File: rtl/ext_irq_pkg.sv
// Shared types for the external interrupt controller.
// Assumes three type bits per line: level select, polarity, both-edge.
package ext_irq_pkg;

    typedef struct packed {
        logic lvl;   // 1: level triggered
        logic sns;   // polarity: 1 high/rising, 0 low/falling
        logic both;  // 1: either edge
    } trig_cfg_t;

    localparam trig_cfg_t TRIG_RESET = '{lvl: 1'b1, sns: 1'b0, both: 1'b0};

    // Both-edge may not be combined with level or polarity.
    function automatic logic trig_ok(input trig_cfg_t t);
        return !(t.both && (t.lvl || t.sns));
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
// Two-flop synchronizer plus one history stage per pin.
// Assumes pins are asynchronous; outputs are the current and previous samples.
module ext_irq_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] smp_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] smp_q;
    logic [W-1:0] prev_q;

    // Shift pins through the synchronizer and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            smp_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            smp_q  <= meta_q;
            prev_q <= smp_q;
        end
    end

    assign smp_o  = smp_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/ext_irq_line.sv
// One interrupt line: holds enable and trigger type, detects events,
// latches edges until cleared, and forms the masked request.
// Assumes smp_i/prev_i are already synchronous to clk.
module ext_irq_line
    import ext_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_i,
    input  logic      prev_i,
    input  logic      cfg_wr_i,
    input  logic      mask_wd_i,
    input  trig_cfg_t trig_wd_i,
    input  logic      clr_i,
    output logic      mask_o,
    output trig_cfg_t trig_o,
    output logic      status_o,
    output logic      req_o
);
    logic      mask_q;
    trig_cfg_t trig_q;
    logic      latch_q;
    logic      rise, fall, hit;

    // Edge classification against the programmed type.
    always_comb begin
        rise = smp_i && !prev_i;
        fall = !smp_i && prev_i;
        if (trig_q.lvl)       hit = 1'b0;
        else if (trig_q.both) hit = rise || fall;
        else if (trig_q.sns)  hit = rise;
        else                  hit = fall;
    end

    // Configuration update; an illegal type leaves the old one in place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            trig_q <= TRIG_RESET;
        end else if (cfg_wr_i) begin
            mask_q <= mask_wd_i;
            if (trig_ok(trig_wd_i)) trig_q <= trig_wd_i;
        end
    end

    // Edge latch: flushed in level mode, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           latch_q <= 1'b0;
        else if (trig_q.lvl)  latch_q <= 1'b0;
        else if (hit)         latch_q <= 1'b1;
        else if (clr_i)       latch_q <= 1'b0;
    end

    // Status is the live level or the held edge.
    assign status_o = trig_q.lvl ? (smp_i == trig_q.sns) : latch_q;
    assign req_o    = status_o && mask_q;
    assign mask_o   = mask_q;
    assign trig_o   = trig_q;

    a_r9_bad_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !trig_ok(trig_wd_i)) |=> $stable(trig_q));
    a_r4_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr_i && !trig_q.lvl) |=> latch_q);
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !latch_q);
    a_r12_level_flush: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q.lvl |=> !latch_q);
endmodule

// File: rtl/ext_irq_regfile.sv
// Word decode for the configuration interface: splits writes into per-line
// strobes and fields, and assembles the read word for the selected index.
// Assumes 6*PER_REG <= DATA_W; positions without a line read 0.
module ext_irq_regfile
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 6,
    parameter int PER_REG   = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 1
) (
    input  logic                        wr_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    input  logic [NUM_LINES-1:0]        mask_i,
    input  trig_cfg_t [NUM_LINES-1:0]   trig_i,
    input  logic [NUM_LINES-1:0]        status_i,
    output logic [NUM_LINES-1:0]        line_wr_o,
    output logic [NUM_LINES-1:0]        clr_o,
    output logic [NUM_LINES-1:0]        mask_wd_o,
    output trig_cfg_t [NUM_LINES-1:0]   trig_wd_o,
    output logic [DATA_W-1:0]           rdata_o
);
    localparam int F_STAT = 0;
    localparam int F_CLR  = PER_REG;
    localparam int F_MASK = 2 * PER_REG;
    localparam int F_SNS  = 3 * PER_REG;
    localparam int F_BOTH = 4 * PER_REG;
    localparam int F_LVL  = 5 * PER_REG;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int RI = g / PER_REG;
        localparam int BP = g % PER_REG;
        assign line_wr_o[g] = wr_i && (wr_idx_i == IDX_W'(RI));
        assign clr_o[g]     = line_wr_o[g] && wdata_i[F_CLR+BP];
        assign mask_wd_o[g] = wdata_i[F_MASK+BP];
        assign trig_wd_o[g] = '{lvl:  wdata_i[F_LVL+BP],
                                sns:  wdata_i[F_SNS+BP],
                                both: wdata_i[F_BOTH+BP]};
    end

    // Read mux: place each line of the selected word at its position.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rd_idx_i == IDX_W'(i / PER_REG)) begin
                rdata_o[F_STAT + i % PER_REG] = status_i[i];
                rdata_o[F_MASK + i % PER_REG] = mask_i[i];
                rdata_o[F_SNS  + i % PER_REG] = trig_i[i].sns;
                rdata_o[F_BOTH + i % PER_REG] = trig_i[i].both;
                rdata_o[F_LVL  + i % PER_REG] = trig_i[i].lvl;
            end
        end
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// Top of the external interrupt controller: synchronizer, per-line
// trigger logic, configuration words and direct/aggregator routing.
// Assumes a single clock and synchronous active-low reset.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int  NUM_LINES = 6,
    parameter int  PER_REG   = 4,
    parameter int  DATA_W    = 32,
    localparam int NUM_REGS  = (NUM_LINES + PER_REG - 1) / PER_REG,
    localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic                 cascade_i,
    input  logic                 cfg_wr_i,
    input  logic [IDX_W-1:0]     cfg_wr_idx_i,
    input  logic [DATA_W-1:0]    cfg_wdata_i,
    input  logic [IDX_W-1:0]     cfg_rd_idx_i,
    output logic [DATA_W-1:0]    cfg_rdata_o,
    output logic [NUM_LINES-1:0] cpu_irq_o,
    output logic [NUM_LINES-1:0] agg_req_o,
    output logic [NUM_LINES-1:0] agg_en_o
);
    logic [NUM_LINES-1:0]      smp, prev;
    logic [NUM_LINES-1:0]      line_wr, line_clr, mask_wd;
    trig_cfg_t [NUM_LINES-1:0] trig_wd, trig_cur;
    logic [NUM_LINES-1:0]      line_mask, line_stat, line_req;

    ext_irq_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .smp_o(smp), .prev_o(prev)
    );

    ext_irq_regfile #(
        .NUM_LINES(NUM_LINES), .PER_REG(PER_REG), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_regs (
        .wr_i(cfg_wr_i), .wr_idx_i(cfg_wr_idx_i), .wdata_i(cfg_wdata_i),
        .rd_idx_i(cfg_rd_idx_i), .mask_i(line_mask), .trig_i(trig_cur),
        .status_i(line_stat), .line_wr_o(line_wr), .clr_o(line_clr),
        .mask_wd_o(mask_wd), .trig_wd_o(trig_wd), .rdata_o(cfg_rdata_o)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        ext_irq_line u_line (
            .clk(clk), .rst_n(rst_n), .smp_i(smp[g]), .prev_i(prev[g]),
            .cfg_wr_i(line_wr[g]), .mask_wd_i(mask_wd[g]), .trig_wd_i(trig_wd[g]),
            .clr_i(line_clr[g]), .mask_o(line_mask[g]), .trig_o(trig_cur[g]),
            .status_o(line_stat[g]), .req_o(line_req[g])
        );
    end

    // Route requests to processor inputs or to the aggregator.
    always_comb begin
        cpu_irq_o = cascade_i ? '0 : line_req;
        agg_req_o = cascade_i ? line_req  : '0;
        agg_en_o  = cascade_i ? line_mask : '0;
    end

    a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req & ~line_mask) == '0);
    a_r11_direct_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_i |-> (cpu_irq_o == '0));
    a_r11_agg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade_i |-> (agg_req_o == '0 && agg_en_o == '0));
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pin = '0;
    logic        cascade = 1'b0;
    logic        wr = 1'b0;
    logic        wr_idx = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_idx = 1'b0;
    logic [31:0] rdata;
    logic [5:0]  cpu_irq, agg_req, agg_en;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cascade_i(cascade),
        .cfg_wr_i(wr), .cfg_wr_idx_i(wr_idx), .cfg_wdata_i(wdata),
        .cfg_rd_idx_i(rd_idx), .cfg_rdata_o(rdata),
        .cpu_irq_o(cpu_irq), .agg_req_o(agg_req), .agg_en_o(agg_en)
    );

    // Behavioural reference model
    bit [5:0] m_s1, m_s2, m_pv, m_lat, m_mask, m_lvl, m_sns, m_both;

    function automatic bit m_stat(input int i);
        return m_lvl[i] ? (m_s2[i] == m_sns[i]) : m_lat[i];
    endfunction

    function automatic logic [31:0] m_read(input int idx);
        logic [31:0] r = '0;
        for (int i = 0; i < 6; i++) begin
            if (i / 4 == idx) begin
                r[i % 4]      = m_stat(i);
                r[8 + i % 4]  = m_mask[i];
                r[12 + i % 4] = m_sns[i];
                r[16 + i % 4] = m_both[i];
                r[20 + i % 4] = m_lvl[i];
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_pv = '0; m_lat = '0;
            m_mask = '0; m_lvl = 6'h3f; m_sns = '0; m_both = '0;
        end else begin
            for (int i = 0; i < 6; i++) begin
                bit up, dn, hit, sel, nl, ns, nb;
                up  = m_s2[i] && !m_pv[i];
                dn  = !m_s2[i] && m_pv[i];
                hit = !m_lvl[i] && (m_both[i] ? (up || dn) : (m_sns[i] ? up : dn));
                sel = wr && (int'(wr_idx) == i / 4);
                if (m_lvl[i]) m_lat[i] = 1'b0;
                else if (hit) m_lat[i] = 1'b1;
                else if (sel && wdata[4 + i % 4]) m_lat[i] = 1'b0;
                if (sel) begin
                    m_mask[i] = wdata[8 + i % 4];
                    nl = wdata[20 + i % 4]; ns = wdata[12 + i % 4]; nb = wdata[16 + i % 4];
                    if (!(nb && (nl || ns))) begin
                        m_lvl[i] = nl; m_sns[i] = ns; m_both[i] = nb;
                    end
                end
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [5:0] req;
            for (int i = 0; i < 6; i++) req[i] = m_stat(i) && m_mask[i];
            chk({26'd0, cpu_irq}, {26'd0, cascade ? 6'd0 : req}, "R11 model cpu_irq");
            chk({26'd0, agg_req}, {26'd0, cascade ? req : 6'd0}, "R11 model agg_req");
            chk({26'd0, agg_en}, {26'd0, cascade ? m_mask : 6'd0}, "R11 model agg_en");
            chk(rdata, m_read(int'(rd_idx)), "R10 model rdata");
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    task automatic wr_word(input logic idx, input logic [31:0] d);
        wr = 1'b1; wr_idx = idx; wdata = d;
        step();
        wr = 1'b0; wdata = '0;
    endtask

    function automatic logic [31:0] cfgw(input logic [3:0] en, input logic [3:0] lv,
                                         input logic [3:0] sn, input logic [3:0] bo,
                                         input logic [3:0] cl);
        return {8'h00, lv, bo, sn, en, cl, 4'h0};
    endfunction

    initial begin
        #(8 * 20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        smp();
        chk(rdata, 32'h00F0000F, "R1 word0 reset");
        chk({26'd0, cpu_irq}, 32'd0, "R1 no request");
        step(); rd_idx = 1'b1; smp();
        chk(rdata, 32'h00300003, "R1 R10 word1 reset");
        step(); rd_idx = 1'b0;

        // R2 level-high on line 0
        wr_word(1'b0, cfgw(4'b0001, 4'b1111, 4'b0001, 4'b0000, 4'b0000));
        pin[0] = 1'b1;
        step(); smp(); chk({31'd0, cpu_irq[0]}, 32'd0, "R2 one edge");
        step(); smp(); chk({31'd0, cpu_irq[0]}, 32'd1, "R2 two edges");
        pin[0] = 1'b0;
        step(); step(); smp(); chk({31'd0, cpu_irq[0]}, 32'd0, "R2 follows pin");

        // R3 level-low on line 1
        wr_word(1'b0, cfgw(4'b0010, 4'b1111, 4'b0001, 4'b0000, 4'b0000));
        smp(); chk({31'd0, cpu_irq[1]}, 32'd1, "R3 low asserts");
        pin[1] = 1'b1;
        step(); step(); smp(); chk({31'd0, cpu_irq[1]}, 32'd0, "R3 high clears");

        // R4 rising edge on line 4
        wr_word(1'b1, cfgw(4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0000));
        pin[4] = 1'b1;
        step(); step(); smp(); chk({31'd0, cpu_irq[4]}, 32'd0, "R4 before latch");
        step(); smp(); chk({31'd0, cpu_irq[4]}, 32'd1, "R4 latched");
        pin[4] = 1'b0;
        repeat (4) step();
        rd_idx = 1'b1; smp();
        chk({31'd0, cpu_irq[4]}, 32'd1, "R4 held after fall");
        chk({31'd0, rdata[0]}, 32'd1, "R4 status read");

        // R7 clear and the coincident edge
        wr_word(1'b1, cfgw(4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0001));
        smp();
        chk({31'd0, cpu_irq[4]}, 32'd0, "R7 cleared");
        chk({28'd0, rdata[7:4]}, 32'd0, "R7 clear reads 0");
        pin[4] = 1'b1;
        step(); step();
        wr_word(1'b1, cfgw(4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0001));
        smp(); chk({31'd0, cpu_irq[4]}, 32'd1, "R7 edge wins over clear");
        wr_word(1'b1, cfgw(4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0001));
        smp(); chk({31'd0, cpu_irq[4]}, 32'd0, "R7 second clear");
        pin[4] = 1'b0;
        repeat (3) step();

        // R5 falling edge on line 5
        wr_word(1'b1, cfgw(4'b0011, 4'b0000, 4'b0001, 4'b0000, 4'b0000));
        pin[5] = 1'b1;
        repeat (4) step(); smp(); chk({31'd0, cpu_irq[5]}, 32'd0, "R5 rise ignored");
        pin[5] = 1'b0;
        repeat (4) step(); smp(); chk({31'd0, cpu_irq[5]}, 32'd1, "R5 fall latched");
        rd_idx = 1'b0;

        // R6 both edges on line 2
        wr_word(1'b0, cfgw(4'b0100, 4'b1011, 4'b0000, 4'b0100, 4'b0000));
        pin[2] = 1'b1;
        repeat (3) step(); smp(); chk({31'd0, cpu_irq[2]}, 32'd1, "R6 rise");
        wr_word(1'b0, cfgw(4'b0100, 4'b1011, 4'b0000, 4'b0100, 4'b0100));
        smp(); chk({31'd0, cpu_irq[2]}, 32'd0, "R6 acknowledged");
        pin[2] = 1'b0;
        repeat (3) step(); smp(); chk({31'd0, cpu_irq[2]}, 32'd1, "R6 fall");

        // R12 level mode flushes the stale latch
        wr_word(1'b0, cfgw(4'b0100, 4'b1111, 4'b0100, 4'b0000, 4'b0000));
        smp(); chk({31'd0, cpu_irq[2]}, 32'd0, "R12 level inactive");
        step();
        wr_word(1'b0, cfgw(4'b0100, 4'b1011, 4'b0000, 4'b0100, 4'b0000));
        smp(); chk({31'd0, cpu_irq[2]}, 32'd0, "R12 no stale edge");

        // R9 illegal type on line 3 refused, enable still taken
        wr_word(1'b0, cfgw(4'b1100, 4'b1011, 4'b1000, 4'b1100, 4'b0000));
        smp();
        chk({28'd0, rdata[23], rdata[19], rdata[15], rdata[11]}, 32'h9, "R9 fields line3");
        chk({31'd0, cpu_irq[3]}, 32'd1, "R9 still level-low");

        // R8 disabled line keeps readable status
        chk({31'd0, rdata[0]}, 32'd1, "R8 status visible");
        chk({31'd0, cpu_irq[0]}, 32'd0, "R8 no request");

        // R11 aggregator routing
        step(); cascade = 1'b1; smp();
        chk({26'd0, cpu_irq}, 32'd0, "R11 direct silent");
        chk({26'd0, agg_en}, 32'h3C, "R11 enables exported");
        chk({31'd0, agg_req[3]}, 32'd1, "R11 request routed");
        step(); cascade = 1'b0;
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule